// File: doc/BRIEF.md
# DQS Delay-Tap Calibration Engine

This block searches for the range of delay-tap settings over which a data-strobe capture path reads memory correctly, and then centres the tap in that range. A sweep begins at a supplied initial tap. The engine first steps the tap upward for as long as trials pass and the tap stays below a ceiling of 0x20. It then goes back to the initial tap and steps downward until a trial fails or the tap reaches zero. The upper and lower edges found by the two sweeps give the final setting: their average goes to one byte lane and that value plus one goes to the other.

The engine does not access memory itself. For each trial it drives the same candidate tap onto both lane outputs and asks an external checker to run a compare, using a start / done / pass handshake. A trial consists of two such runs. A built-in pattern generator supplies the data words that the checker writes and compares, one registered word per address.

Top module: `dqs_tap_calib`

## Requirements
- R1: After reset, `busy`, `done`, `test_go`, `lane0_tap` and `lane1_tap` are all 0.
- R2: A `start` pulse while idle captures `init_tap` and raises `busy` on the next clock. At every `test_go` pulse both lane outputs carry the same trial tap and `busy` is high.
- R3: A trial asks for a second checker run only when the first run passes. A trial passes when both runs pass. A failed run ends the trial immediately, so a failing trial uses exactly one run.
- R4: During the upward sweep, a passing trial at a tap below 0x20 makes the next trial use that tap plus one.
- R5: During the upward sweep, a passing trial at a tap of 0x20 or above sets the upper edge to that tap. The next trial is then the initial tap again, now sweeping downward.
- R6: During the upward sweep, a failing trial sets the upper edge to the failing tap minus one (6-bit unsigned). The next trial is the initial tap, sweeping downward.
- R7: During the downward sweep, a passing trial at a nonzero tap makes the next trial use that tap minus one. A failing trial sets the lower edge to the failing tap plus one. A passing trial at tap 0 sets the lower edge to 0. Either of the last two ends the search.
- R8: When the search ends, `lane0_tap` becomes floor((upper+lower)/2) and `lane1_tap` becomes that value plus one. `done` pulses high for one cycle in the same cycle that `busy` falls. Both lanes hold their values until the next start.
- R9: `pat_word` is registered with one cycle of latency. Address bits [9:2] select a group g and bits [1:0] select a word k. The low 16 bits are 0xFFFF when bit 2k of g is 1 and 0 otherwise. The high 16 bits are 0xFFFF when bit 2k+1 of g is 1 and 0 otherwise.
- R10: A `start` pulse while `busy` is high has no effect on the sweep or on its final taps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a calibration (one-cycle pulse) |
| init_tap | input | 6 | Tap at which both sweeps begin |
| test_go | output | 1 | One-cycle request to the checker to run a compare |
| test_done | input | 1 | Checker has finished the current run |
| test_pass | input | 1 | Result of the run, valid with `test_done` |
| lane0_tap | output | 6 | Tap for byte lane 0 |
| lane1_tap | output | 6 | Tap for byte lane 1 |
| busy | output | 1 | Calibration in progress |
| done | output | 1 | One-cycle completion pulse |
| pat_addr | input | 10 | Pattern word address |
| pat_word | output | 32 | Pattern word for the previous cycle's address |

## Verification
Most internal faults in this block reach the ports quickly. A wrong step, direction or bound shows up at the lane outputs on the next `test_go`, because the trial tap is visible there one cycle after each checker result. A wrong edge or midpoint shows up in the final taps in the cycle `done` pulses. A run-count fault shows up as a different number of checker requests per search. A pattern fault is wrong one cycle after the address is applied. The bench uses a checker model that passes only inside a chosen window, and compares the final taps with values derived from that window and from the initial tap.

// File: rtl/calib_pkg.sv
package calib_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LAUNCH = 2'd1,
    ST_WAIT   = 2'd2,
    ST_FINAL  = 2'd3
  } calib_state_t;
endpackage

// File: rtl/calib_pattern_gen.sv
module calib_pattern_gen #(
  parameter int GROUPS = 256,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32
) (
  input  logic                                         clk,
  input  logic                                         rst,
  input  logic [$clog2(GROUPS)+$clog2(WORDS)-1:0]      addr,
  output logic [DATA_W-1:0]                            word
);
  localparam int GRP_W  = $clog2(GROUPS);
  localparam int SEL_W  = $clog2(WORDS);
  localparam int ADDR_W = GRP_W + SEL_W;
  localparam int HALF_W = DATA_W / 2;

  logic [GRP_W-1:0]  grp;
  logic [GRP_W-1:0]  shifted;
  logic [DATA_W-1:0] next_word;

  assign grp     = addr[ADDR_W-1:SEL_W];
  assign shifted = grp >> {addr[SEL_W-1:0], 1'b0};

  for (genvar h = 0; h < 2; h++) begin : g_half
    assign next_word[h*HALF_W +: HALF_W] = {HALF_W{shifted[h]}};
  end

  always_ff @(posedge clk) begin
    if (rst) word <= '0;
    else     word <= next_word;
  end

  // R9
  half_uniform_chk: assert property (@(posedge clk) disable iff (rst)
    (word[HALF_W-1:0] == '0 || word[HALF_W-1:0] == '1) &&
    (word[DATA_W-1:HALF_W] == '0 || word[DATA_W-1:HALF_W] == '1));
endmodule

// File: rtl/calib_midpoint.sv
module calib_midpoint #(
  parameter int TAP_W = 6
) (
  input  logic [TAP_W-1:0] upper,
  input  logic [TAP_W-1:0] lower,
  output logic [TAP_W-1:0] mid,
  output logic [TAP_W-1:0] mid_p1
);
  logic [TAP_W:0] sum;
  assign sum    = {1'b0, upper} + {1'b0, lower};
  assign mid    = sum[TAP_W:1];
  assign mid_p1 = sum[TAP_W:1] + 1'b1;
endmodule

// File: rtl/calib_sweep.sv
module calib_sweep
  import calib_pkg::*;
#(
  parameter int TAP_W    = 6,
  parameter int TAP_CEIL = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [TAP_W-1:0] init_tap,
  input  logic             chk_done,
  input  logic             chk_pass,
  output logic             chk_go,
  output logic [TAP_W-1:0] lane0,
  output logic [TAP_W-1:0] lane1,
  output logic             busy,
  output logic             done
);
  localparam logic [TAP_W-1:0] CEIL = TAP_W'(TAP_CEIL);

  calib_state_t     state;
  logic [TAP_W-1:0] cur, base, upper, lower, mid, mid_p1;
  logic             going_up, second;

  calib_midpoint #(.TAP_W(TAP_W)) u_mid (
    .upper(upper), .lower(lower), .mid(mid), .mid_p1(mid_p1)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE; cur <= '0; base <= '0; upper <= '0; lower <= '0;
      going_up <= 1'b0; second <= 1'b0; chk_go <= 1'b0;
      lane0 <= '0; lane1 <= '0; busy <= 1'b0; done <= 1'b0;
    end else begin
      chk_go <= 1'b0;
      done   <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          cur <= init_tap; base <= init_tap;
          going_up <= 1'b1; second <= 1'b0; busy <= 1'b1;
          state <= ST_LAUNCH;
        end
        ST_LAUNCH: begin
          lane0 <= cur; lane1 <= cur; chk_go <= 1'b1;
          state <= ST_WAIT;
        end
        ST_WAIT: if (chk_done) begin
          state <= ST_LAUNCH;
          if (chk_pass && !second) begin
            second <= 1'b1;
          end else begin
            second <= 1'b0;
            if (!chk_pass) begin
              if (going_up) begin
                upper <= cur - 1'b1; cur <= base; going_up <= 1'b0;
              end else begin
                lower <= cur + 1'b1; state <= ST_FINAL;
              end
            end else if (going_up) begin
              if (cur < CEIL) cur <= cur + 1'b1;
              else begin
                upper <= cur; cur <= base; going_up <= 1'b0;
              end
            end else if (cur == '0) begin
              lower <= '0; state <= ST_FINAL;
            end else begin
              cur <= cur - 1'b1;
            end
          end
        end
        ST_FINAL: begin
          lane0 <= mid; lane1 <= mid_p1;
          busy <= 1'b0; done <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2
  lanes_match_chk: assert property (@(posedge clk) disable iff (rst)
    chk_go |-> (lane0 == lane1) && busy);

  // R8
  finish_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy && (lane1 == lane0 + 1'b1));

  // R10
  base_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(base));

  // R4
  step_up_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && chk_done && chk_pass && second && going_up && cur < CEIL)
      |=> cur == $past(cur) + 1'b1);
endmodule

// File: rtl/dqs_tap_calib.sv
module dqs_tap_calib #(
  parameter int TAP_W    = 6,
  parameter int TAP_CEIL = 32,
  parameter int GROUPS   = 256,
  parameter int WORDS    = 4,
  parameter int DATA_W   = 32
) (
  input  logic                                    clk,
  input  logic                                    rst,
  input  logic                                    start,
  input  logic [TAP_W-1:0]                        init_tap,
  output logic                                    test_go,
  input  logic                                    test_done,
  input  logic                                    test_pass,
  output logic [TAP_W-1:0]                        lane0_tap,
  output logic [TAP_W-1:0]                        lane1_tap,
  output logic                                    busy,
  output logic                                    done,
  input  logic [$clog2(GROUPS)+$clog2(WORDS)-1:0] pat_addr,
  output logic [DATA_W-1:0]                       pat_word
);
  calib_sweep #(.TAP_W(TAP_W), .TAP_CEIL(TAP_CEIL)) u_sweep (
    .clk(clk), .rst(rst), .start(start), .init_tap(init_tap),
    .chk_done(test_done), .chk_pass(test_pass), .chk_go(test_go),
    .lane0(lane0_tap), .lane1(lane1_tap), .busy(busy), .done(done)
  );

  calib_pattern_gen #(.GROUPS(GROUPS), .WORDS(WORDS), .DATA_W(DATA_W)) u_pat (
    .clk(clk), .rst(rst), .addr(pat_addr), .word(pat_word)
  );
endmodule

// File: tb/sim_dqs_tap_calib.sv
module sim_dqs_tap_calib;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [5:0]  init_tap = '0;
  logic        test_go;
  logic        test_done = 1'b0;
  logic        test_pass = 1'b0;
  logic [5:0]  lane0_tap, lane1_tap;
  logic        busy, done;
  logic [9:0]  pat_addr = '0;
  logic [31:0] pat_word;

  int checks = 0;
  int fails  = 0;
  int win_lo = 0, win_hi = 0;
  int fail2_tap = -1;
  int runs = 0;
  int lane_bad = 0;
  int prev_tap = -1;
  bit prev_pass = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  dqs_tap_calib u0 (
    .clk(clk), .rst(rst), .start(start), .init_tap(init_tap),
    .test_go(test_go), .test_done(test_done), .test_pass(test_pass),
    .lane0_tap(lane0_tap), .lane1_tap(lane1_tap), .busy(busy), .done(done),
    .pat_addr(pat_addr), .pat_word(pat_word)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Checker model: passes only when the lane tap lies in [win_lo, win_hi]
  initial begin
    forever begin
      @(posedge clk); #1;
      if (test_go) begin
        bit ok;
        runs++;
        if (lane0_tap != lane1_tap || !busy) lane_bad++;
        ok = (int'(lane0_tap) >= win_lo) && (int'(lane0_tap) <= win_hi);
        if (int'(lane0_tap) == fail2_tap && prev_tap == fail2_tap && prev_pass) ok = 0;
        prev_tap = int'(lane0_tap);
        prev_pass = ok;
        repeat (2) @(posedge clk);
        #1; test_done = 1'b1; test_pass = ok;
        @(posedge clk); #1; test_done = 1'b0; test_pass = 1'b0;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic kick(input int tap);
    @(posedge clk); #1; start = 1'b1; init_tap = 6'(tap);
    @(posedge clk); #1; start = 1'b0;
    check("R2 busy after start", busy, 1);
  endtask

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int i = 0; i < 5000; i++) begin
      @(posedge clk); #1;
      if (done) begin ok = 1; break; end
    end
  endtask

  task automatic run_search(input string tag, input int lo, input int hi, input int tap,
                            input int exp0, input int exp_runs, input bit poke);
    bit ok;
    win_lo = lo; win_hi = hi; runs = 0; lane_bad = 0; prev_tap = -1; prev_pass = 0;
    kick(tap);
    if (poke) begin
      repeat (5) @(posedge clk); #1; start = 1'b1; init_tap = 6'd30;
      @(posedge clk); #1; start = 1'b0;
    end
    wait_done(ok);
    check({tag, " completes"}, ok, 1);
    check({tag, " R8 lane0"}, lane0_tap, exp0);
    check({tag, " R8 lane1"}, lane1_tap, exp0 + 1);
    check({tag, " R8 busy low with done"}, busy, 0);
    check({tag, " R2 lanes equal at each run"}, lane_bad, 0);
    if (exp_runs >= 0) check({tag, " R3 run count"}, runs, exp_runs);
    @(posedge clk); #1;
    check({tag, " R8 done one cycle"}, done, 0);
    check({tag, " R8 lane0 held"}, lane0_tap, exp0);
  endtask

  task automatic t_reset;
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 test_go", test_go, 0);
    check("R1 lane0", lane0_tap, 0);
    check("R1 lane1", lane1_tap, 0);
  endtask

  // R4 R6 R7 R3 R10: window 5..20 from 12, upper 20 lower 5, with a stray start
  task automatic t_inside;
    run_search("R4_R6_R7_R10 inside", 5, 20, 12, 12, 36, 1);
  endtask

  // R5 R7: ceiling reached going up, tap 0 passes going down -> (32+0)/2
  task automatic t_ceiling;
    run_search("R5 ceiling", 0, 40, 3, 16, -1, 0);
  endtask

  // R6 R7: initial tap outside the window -> upper tap-1, lower tap+1
  task automatic t_outside;
    run_search("R6 outside", 20, 30, 10, 10, 2, 0);
  endtask

  // R5: initial tap above the ceiling -> upper is the tap itself; lower 30
  task automatic t_above;
    run_search("R5 above ceiling", 30, 50, 40, 35, -1, 0);
  endtask

  // R3: second run fails at tap 12 -> upper 11, lower 4 -> 7
  task automatic t_second_run;
    fail2_tap = 12;
    run_search("R3 second run", 4, 15, 8, 7, 21, 0);
    fail2_tap = -1;
  endtask

  function automatic logic [31:0] pat_exp(input int a);
    int g = a >> 2;
    int k = a & 3;
    logic [31:0] w = '0;
    if ((g >> (2*k)) & 1) w[15:0] = 16'hFFFF;
    if ((g >> (2*k+1)) & 1) w[31:16] = 16'hFFFF;
    return w;
  endfunction

  // R9 pattern generator over every address
  task automatic t_pattern;
    int bad = 0;
    logic [31:0] first_bad_act = '0, first_bad_exp = '0;
    for (int a = 0; a < 1024; a++) begin
      @(posedge clk); #1; pat_addr = 10'(a);
      @(posedge clk); #1;
      if (pat_word !== pat_exp(a)) begin
        if (bad == 0) begin first_bad_act = pat_word; first_bad_exp = pat_exp(a); end
        bad++;
      end
    end
    check("R9 pattern mismatches", bad, 0);
    check("R9 first mismatch word", int'(first_bad_act), int'(first_bad_exp));
    @(posedge clk); #1; pat_addr = 10'h2E7;
    @(posedge clk); #1;
    check("R9 address 0x2E7", int'(pat_word), int'(32'hFFFF0000));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1; rst = 1'b0;
    t_reset();
    t_inside();
    t_ceiling();
    t_outside();
    t_above();
    t_second_run();
    t_pattern();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule